// File: doc/BRIEF.md
# Circular Serial Byte Pump with Half and Full Events

This block sends the contents of a small circular byte buffer out on a single serial data line. The bit clock comes from the far end, as it would for a transmit-only serial peripheral, at roughly 9600 bits per second. That clock is brought into the system clock domain, and the data line moves on the falling (trailing) edge of each pulse, so the far end can sample on the rising edge. The first bit of a transfer is already on the line when the transfer starts.

Firmware fills the buffer through a simple byte write port. It then issues a start strobe with a mode bit (circular or single pass) and an optional total byte count. As the stream passes the middle of the buffer a half event is flagged, and at the end of the buffer a full event is flagged. Firmware refills each half after its event and acknowledges it with a clear strobe, which gives ping-pong double buffering. If the stream comes back into a half whose event was never acknowledged, an underrun is flagged. Each flag can be polled or routed to an interrupt line.

Top module: `circ_stream_pump`

## Requirements
- R1: A byte written with `wr_en` at `wr_addr` is the byte that is later streamed when the read pointer reaches that address. Bytes go out in ascending address order, starting at address 0.
- R2: Each byte is sent most significant bit first. `sdo` changes only as a result of a falling edge of `ext_sck`, and it changes on the third rising edge of `clk` after that falling edge. The most significant bit of byte 0 appears one cycle after an accepted start.
- R3: After reset, `sdo`, `active`, all three flags and `irq` are 0.
- R4: `half_flag` is set in the cycle in which the eighth bit of the byte at address DEPTH/2-1 is shifted out.
- R5: `full_flag` is set when the byte at address DEPTH-1 completes. In circular mode the stream then continues at address 0. In single-pass mode it stops, `active` falls and `sdo` returns to 0. Further clock pulses while stopped have no effect.
- R6: A nonzero `total_bytes` stops the stream after exactly that many bytes, wrapping included. A value of 0 means no limit.
- R7: `underrun_flag` is set when the stream moves on to address 0 while `half_flag` is set, or moves on to address DEPTH/2 while `full_flag` is set.
- R8: The flags are sticky until their clear strobe (`clr_half`, `clr_full`, `clr_under`) is high at a clock edge. A set event in the same cycle as its clear strobe wins.
- R9: `irq` is high when `underrun_flag` is set, when `half_flag` and `ie_half` are both set, or when `full_flag` and `ie_full` are both set. It follows its inputs with no delay.
- R10: An accepted start (`start` high while `active` is low) clears all three flags. A start while `active` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | AW | Buffer byte address |
| wr_data | input | 8 | Buffer byte value |
| start | input | 1 | Begin a transfer at address 0 |
| circ_mode | input | 1 | 1: wrap at end of buffer, 0: single pass |
| total_bytes | input | CNT_W | Bytes to send, 0 for unlimited |
| clr_half | input | 1 | Clear half event flag |
| clr_full | input | 1 | Clear full event flag |
| clr_under | input | 1 | Clear underrun flag |
| ie_half | input | 1 | Route half flag to irq |
| ie_full | input | 1 | Route full flag to irq |
| ext_sck | input | 1 | External bit clock, asynchronous, idle low |
| sdo | output | 1 | Serial data out |
| active | output | 1 | Transfer in progress |
| half_flag | output | 1 | First half sent |
| full_flag | output | 1 | Second half sent |
| underrun_flag | output | 1 | Unacknowledged half re-entered |
| irq | output | 1 | Interrupt request |

## Verification
A falling edge of `ext_sck` reaches `sdo` on the third rising edge of `clk`. The flag that goes with the eighth bit of a byte rises on that same edge, and `irq` follows the flags and enables within the same cycle. The bench keeps a three-deep history of the bit clock as sampled on each rising edge and steps its behavioural model on the edge where the design acts. It compares every output 2 ns after each rising edge, so inputs that change on falling edges are settled when they are read. The named end-of-scenario checks wait at least four idle cycles after the last falling edge of the bit clock, so no event is still in the pipeline.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int FLAG_HALF  = 0;
  localparam int FLAG_FULL  = 1;
  localparam int FLAG_UNDER = 2;
  localparam int NFLAGS     = 3;
  typedef logic [NFLAGS-1:0] csp_flags_t;
endpackage

// File: rtl/csp_edge_sync.sv
module csp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);
  // sr[0], sr[1]: two-flop synchroniser; sr[2]: delayed copy for edge detect
  logic [2:0] sr_q;
  logic [2:0] sr_d;

  always_comb sr_d = {sr_q[1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign fall_pulse = sr_q[2] & ~sr_q[1];
endmodule

// File: rtl/csp_buf_mem.sv
module csp_buf_mem #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/csp_flag_unit.sv
module csp_flag_unit
  import csp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  csp_flags_t set_ev,
  input  csp_flags_t clr_ev,
  output csp_flags_t flags
);
  csp_flags_t flags_d;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_comb begin
      if (clr_all) flags_d[i] = 1'b0;
      else         flags_d[i] = (flags[i] & ~clr_ev[i]) | set_ev[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/circ_stream_pump.sv
module circ_stream_pump
  import csp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             start,
  input  logic             circ_mode,
  input  logic [CNT_W-1:0] total_bytes,
  input  logic             clr_half,
  input  logic             clr_full,
  input  logic             clr_under,
  input  logic             ie_half,
  input  logic             ie_full,
  input  logic             ext_sck,
  output logic             sdo,
  output logic             active,
  output logic             half_flag,
  output logic             full_flag,
  output logic             underrun_flag,
  output logic             irq
);
  localparam logic [AW-1:0] HALF_FIRST = AW'(DEPTH / 2);
  localparam logic [AW-1:0] HALF_LAST  = AW'(DEPTH / 2 - 1);
  localparam logic [AW-1:0] BUF_LAST   = AW'(DEPTH - 1);

  logic             sck_fall;
  logic [AW-1:0]    ptr_q, ptr_d, nxt_ptr, rd_addr;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rd_data;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             lim_q, lim_d, circ_q, circ_d, act_d;
  logic             start_go, byte_done, stop_now, seq_en;
  csp_flags_t       set_ev, clr_ev, flags;

  csp_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_sck), .fall_pulse(sck_fall)
  );

  assign nxt_ptr = ptr_q + 1'b1;
  assign rd_addr = active ? nxt_ptr : '0;

  csp_buf_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign start_go  = start & ~active;
  assign byte_done = active & sck_fall & (bit_q == 3'd7);
  assign stop_now  = byte_done &
                     ((lim_q & (rem_q == CNT_W'(1))) | ((ptr_q == BUF_LAST) & ~circ_q));
  assign seq_en    = start_go | (active & sck_fall);

  // next-state for the sequencer
  always_comb begin
    act_d  = active;
    ptr_d  = ptr_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rem_d  = rem_q;
    lim_d  = lim_q;
    circ_d = circ_q;
    if (start_go) begin
      act_d  = 1'b1;
      ptr_d  = '0;
      bit_d  = '0;
      sh_d   = rd_data;
      rem_d  = total_bytes;
      lim_d  = |total_bytes;
      circ_d = circ_mode;
    end else if (active & sck_fall) begin
      if (bit_q != 3'd7) begin
        sh_d  = {sh_q[6:0], 1'b0};
        bit_d = bit_q + 3'd1;
      end else if (stop_now) begin
        act_d = 1'b0;
        sh_d  = '0;
      end else begin
        ptr_d = nxt_ptr;
        bit_d = '0;
        sh_d  = rd_data;
        if (lim_q) rem_d = rem_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
      lim_q  <= 1'b0;
      circ_q <= 1'b0;
    end else if (seq_en) begin
      active <= act_d;
      ptr_q  <= ptr_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      lim_q  <= lim_d;
      circ_q <= circ_d;
    end
  end

  always_comb begin
    set_ev             = '0;
    set_ev[FLAG_HALF]  = byte_done & (ptr_q == HALF_LAST);
    set_ev[FLAG_FULL]  = byte_done & (ptr_q == BUF_LAST);
    set_ev[FLAG_UNDER] = byte_done & ~stop_now &
                         (((nxt_ptr == '0) & flags[FLAG_HALF]) |
                          ((nxt_ptr == HALF_FIRST) & flags[FLAG_FULL]));
    clr_ev             = '0;
    clr_ev[FLAG_HALF]  = clr_half;
    clr_ev[FLAG_FULL]  = clr_full;
    clr_ev[FLAG_UNDER] = clr_under;
  end

  csp_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .clr_all(start_go),
    .set_ev(set_ev), .clr_ev(clr_ev), .flags(flags)
  );

  assign sdo           = sh_q[7];
  assign half_flag     = flags[FLAG_HALF];
  assign full_flag     = flags[FLAG_FULL];
  assign underrun_flag = flags[FLAG_UNDER];
  assign irq           = flags[FLAG_UNDER] | (flags[FLAG_HALF] & ie_half) |
                         (flags[FLAG_FULL] & ie_full);
endmodule

// File: rtl/csp_chk.sv
module csp_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_fall,
  input logic sdo,
  input logic active,
  input logic half_flag,
  input logic full_flag,
  input logic underrun_flag,
  input logic clr_half,
  input logic clr_full,
  input logic irq
);
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    active && !sck_fall |=> $stable(sdo));                          // R2
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdo);                                              // R5
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    half_flag && !clr_half |=> half_flag);                          // R8
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag && !clr_full |=> full_flag);                          // R8
  AST_UNDER_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_flag) |-> active);                               // R7
  AST_UNDER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_flag |-> irq);                                         // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !half_flag && !full_flag && !underrun_flag);  // R10
endmodule

bind circ_stream_pump csp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .sdo(sdo), .active(active),
  .half_flag(half_flag), .full_flag(full_flag), .underrun_flag(underrun_flag),
  .clr_half(clr_half), .clr_full(clr_full), .irq(irq)
);

// File: tb/circ_stream_pump_tb.sv
`timescale 1ns/1ps
module circ_stream_pump_tb;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, circ_mode = 1'b0, ext_sck = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [CNT_W-1:0] total_bytes = '0;
  logic clr_half = 1'b0, clr_full = 1'b0, clr_under = 1'b0;
  logic ie_half = 1'b0, ie_full = 1'b0;
  logic sdo, active, half_flag, full_flag, underrun_flag, irq;

  int checks = 0, failures = 0, half_seen = 0;

  always #10 clk = ~clk;

  circ_stream_pump #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .circ_mode(circ_mode), .total_bytes(total_bytes),
    .clr_half(clr_half), .clr_full(clr_full), .clr_under(clr_under),
    .ie_half(ie_half), .ie_full(ie_full), .ext_sck(ext_sck), .sdo(sdo),
    .active(active), .half_flag(half_flag), .full_flag(full_flag),
    .underrun_flag(underrun_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mem [DEPTH];
  int m_act, m_ptr, m_bit, m_sh, m_rem, m_lim, m_circ, mh, mf, mu;
  int h1, h2, h3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_ptr = 0; m_bit = 0; m_sh = 0; m_rem = 0; m_lim = 0; m_circ = 0;
      mh = 0; mf = 0; mu = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      int ev_h, ev_f, ev_u, nxt;
      ev_h = 0; ev_f = 0; ev_u = 0;
      if (start && !m_act) begin
        m_act = 1; m_ptr = 0; m_bit = 0; m_sh = m_mem[0];
        m_rem = int'(total_bytes); m_lim = (total_bytes != 0); m_circ = int'(circ_mode);
        mh = 0; mf = 0; mu = 0;
      end else begin
        if (m_act != 0 && h3 == 1 && h2 == 0) begin
          if (m_bit < 7) begin
            m_sh = (m_sh << 1) & 255; m_bit++;
          end else begin
            if (m_ptr == HALF - 1)  ev_h = 1;
            if (m_ptr == DEPTH - 1) ev_f = 1;
            if ((m_lim != 0 && m_rem == 1) || (m_ptr == DEPTH - 1 && m_circ == 0)) begin
              m_act = 0; m_sh = 0;
            end else begin
              nxt = (m_ptr + 1) % DEPTH;
              if ((nxt == 0 && mh != 0) || (nxt == HALF && mf != 0)) ev_u = 1;
              m_ptr = nxt; m_bit = 0; m_sh = m_mem[nxt];
              if (m_lim != 0) m_rem--;
            end
          end
        end
        mh = ((mh != 0 && !clr_half)  || ev_h != 0) ? 1 : 0;
        mf = ((mf != 0 && !clr_full)  || ev_f != 0) ? 1 : 0;
        mu = ((mu != 0 && !clr_under) || ev_u != 0) ? 1 : 0;
      end
      if (wr_en) m_mem[wr_addr] = int'(wr_data);
      h3 = h2; h2 = h1; h1 = int'(ext_sck);
      #2;
      if (rst_n) begin
        chk("R1 R2 sdo", int'(sdo), (m_sh >> 7) & 1);
        chk("R5 R6 active", int'(active), m_act);
        chk("R4 half_flag", int'(half_flag), mh);
        chk("R5 full_flag", int'(full_flag), mf);
        chk("R7 underrun_flag", int'(underrun_flag), mu);
        chk("R9 irq", int'(irq), (mu != 0 || (mh != 0 && ie_half) || (mf != 0 && ie_full)) ? 1 : 0);
        if (half_flag) half_seen++;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bits(input int n);
    repeat (n) begin
      @(negedge clk); ext_sck = 1'b1; cycles(3);
      @(negedge clk); ext_sck = 1'b0; cycles(3);
    end
    cycles(5);
  endtask

  task automatic pulse_start(input logic circ, input int total);
    @(negedge clk); start = 1'b1; circ_mode = circ; total_bytes = CNT_W'(total);
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R3: reset state
    chk("R3 sdo", int'(sdo), 0);
    chk("R3 active", int'(active), 0);
    chk("R3 flags", int'({half_flag, full_flag, underrun_flag}), 0);
    chk("R3 irq", int'(irq), 0);

    // R1: fill buffer
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'((a * 37 + 5) & 255);
    end
    @(negedge clk); wr_en = 1'b0;

    // R5: single pass, unlimited count, extra pulses after stop
    pulse_start(1'b0, 0);
    chk("R2 first bit", int'(sdo), ((5 >> 7) & 1));
    sck_bits(DEPTH * 8 + 8);
    chk("R5 stopped", int'(active), 0);
    chk("R4 half set", int'(half_flag), 1);
    chk("R5 full set", int'(full_flag), 1);
    chk("R5 idle sdo", int'(sdo), 0);

    // R8: clear strobes
    @(negedge clk); clr_half = 1'b1; clr_full = 1'b1;
    @(negedge clk); clr_half = 1'b0; clr_full = 1'b0;
    chk("R8 half cleared", int'(half_flag), 0);
    chk("R8 full cleared", int'(full_flag), 0);

    // R6 / R8: circular, limited to 20 bytes, clears held high (set wins)
    @(negedge clk); clr_half = 1'b1; clr_full = 1'b1; half_seen = 0;
    pulse_start(1'b1, 20);
    sck_bits(20 * 8 + 16);
    chk("R6 stopped after count", int'(active), 0);
    chk("R7 no underrun when acked", int'(underrun_flag), 0);
    chk("R8 set beats clear", (half_seen > 0) ? 1 : 0, 1);
    @(negedge clk); clr_half = 1'b0; clr_full = 1'b0;

    // R6 unlimited, R7 underrun without acknowledges
    pulse_start(1'b1, 0);
    sck_bits(20 * 8);
    chk("R6 unlimited still active", int'(active), 1);
    chk("R7 underrun set", int'(underrun_flag), 1);
    chk("R9 irq from underrun", int'(irq), 1);

    // R10: start while active ignored
    pulse_start(1'b0, 1);
    chk("R10 still active", int'(active), 1);
    chk("R10 flags kept", int'(underrun_flag), 1);

    // R9: enables
    @(negedge clk); clr_under = 1'b1;
    @(negedge clk); clr_under = 1'b0;
    chk("R9 irq masked", int'(irq), 0);
    @(negedge clk); ie_full = 1'b1;
    #1 chk("R9 irq full enabled", int'(irq), 1);
    @(negedge clk); ie_full = 1'b0; ie_half = 1'b1;
    #1 chk("R9 irq half enabled", int'(irq), 1);

    // R3: reset mid-stream
    @(negedge clk); rst_n = 1'b0; ie_half = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(2);
    chk("R3 after reset active", int'(active), 0);
    chk("R3 after reset flags", int'({half_flag, full_flag, underrun_flag, irq}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule